// File: doc/BRIEF.md
# Sector Write-Lock Controller

This block keeps one write-lock flag for each sector of a flash array and enforces write protection from those flags. A bus-write port carries command cycles. The block watches them for a six-cycle lock sequence. When the sequence completes, the flag of the sector named in the last cycle is set. Only a reset clears the flags, and no command can clear them.

The program/erase sequencer asks the block about each program or erase request by presenting the sector index. In the same cycle the block answers with either an allow or a deny. The deny is the protection fault that the status logic turns into its failure bit. The array itself and erase timing are outside the block.

While the device is in identification mode, a read at in-sector offset 2 returns that sector's lock flag in bit 0. All other bits of that read are 0.

Top module: `sector_lock_ctrl`

## Requirements
- R1: After reset every lock flag is 0. Every identification-mode read at offset 2 then returns 00h, and every request is allowed.
- R2: A sector's flag is set by six consecutive bus writes, with no other writes between them. As (in-sector offset, data) pairs they are: (555h, AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), (any offset, 60h). The sector bits of the first five writes are don't-care. The sector field (top SECT_W address bits) of the sixth write selects the sector. No other sector's flag changes.
- R3: When req_valid is 1 and the requested sector is locked, req_deny is 1 and req_allow is 0 in the same cycle.
- R4: When req_valid is 1 and the sector is unlocked, req_allow is 1 and req_deny is 0. When req_valid is 0, both outputs are 0.
- R5: An rd_en with id_mode=1 and in-sector offset 2 makes rd_data equal {7'b0, flag of that sector} on the cycle after the read.
- R6: Any other read, and any cycle without rd_en, gives rd_data = 00h on the following cycle.
- R7: A write that does not match the expected step returns the decoder to idle. That write does not count as a first step, so the whole six-write sequence must be issued again.
- R8: Once set, a flag stays set until reset, whatever writes, reads or requests follow.
- R9: A request to the sector named by a completing sixth write in the same cycle is already denied. A read of that sector in that cycle already returns 1.
- R10: Reads and requests between the command writes do not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all flags |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address; top SECT_W bits select the sector |
| wr_data | input | 8 | Bus write data |
| req_valid | input | 1 | Program/erase request present |
| req_sect | input | SECT_W | Sector targeted by the request |
| req_allow | output | 1 | Request may proceed |
| req_deny | output | 1 | Request refused, protection fault |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| id_mode | input | 1 | Identification mode active |
| rd_data | output | 8 | Read data, registered one cycle after rd_en |

## Verification
A sixth lock write can arrive in the same cycle as a program/erase request or an identification read aimed at the very sector being locked. The request must already be refused and the read must already return 1. Directed cycles place the completing write, a request and a read on one sector together. Random cycles also mix good command steps, stray writes, requests and reads, so these collisions and the near misses to neighbouring sectors recur. A bench model judges every cycle by applying the new flag before deciding the request and read expectations.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;

    localparam int DATA_W = 8;

    localparam logic [10:0] UNLK_OFS_A = 11'h555;
    localparam logic [10:0] UNLK_OFS_B = 11'h2AA;
    localparam logic [7:0]  UNLK_DAT_A = 8'hAA;
    localparam logic [7:0]  UNLK_DAT_B = 8'h55;
    localparam logic [7:0]  SETUP_DAT  = 8'h80;
    localparam logic [7:0]  LOCK_DAT   = 8'h60;

    // number of command steps already accepted
    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_UA1   = 3'd1,
        SEQ_UB1   = 3'd2,
        SEQ_SETUP = 3'd3,
        SEQ_UA2   = 3'd4,
        SEQ_UB2   = 3'd5
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
    } seq_regs_t;

endpackage

// File: rtl/slc_cmd_seq.sv
module slc_cmd_seq
    import sector_lock_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [SECT_W-1:0] wr_sect,
    input  logic [DATA_W-1:0] wr_data,
    output logic              set_fire,
    output logic [SECT_W-1:0] set_sect
);

    seq_regs_t seq_d, seq_q;

    function automatic logic step_ok(input logic [OFS_W-1:0] ofs, input logic [DATA_W-1:0] dat,
                                     input logic [10:0] want_ofs, input logic [7:0] want_dat);
        return (ofs == OFS_W'(want_ofs)) && (dat == want_dat);
    endfunction

    always_comb begin
        seq_d    = seq_q;
        set_fire = 1'b0;
        set_sect = wr_sect;
        if (wr_en) begin
            seq_d.st = SEQ_IDLE;
            unique case (seq_q.st)
                SEQ_IDLE:  if (step_ok(wr_ofs, wr_data, UNLK_OFS_A, UNLK_DAT_A)) seq_d.st = SEQ_UA1;
                SEQ_UA1:   if (step_ok(wr_ofs, wr_data, UNLK_OFS_B, UNLK_DAT_B)) seq_d.st = SEQ_UB1;
                SEQ_UB1:   if (step_ok(wr_ofs, wr_data, UNLK_OFS_A, SETUP_DAT))  seq_d.st = SEQ_SETUP;
                SEQ_SETUP: if (step_ok(wr_ofs, wr_data, UNLK_OFS_A, UNLK_DAT_A)) seq_d.st = SEQ_UA2;
                SEQ_UA2:   if (step_ok(wr_ofs, wr_data, UNLK_OFS_B, UNLK_DAT_B)) seq_d.st = SEQ_UB2;
                SEQ_UB2:   set_fire = (wr_data == LOCK_DAT);
                default:   seq_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE};
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/slc_lock_bank.sv
module slc_lock_bank #(
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_fire,
    input  logic [SECT_W-1:0] set_sect,
    output logic [NSECT-1:0]  lock_q,
    output logic [NSECT-1:0]  lock_eff
);

    typedef struct packed {
        logic [NSECT-1:0] lock;
    } bank_regs_t;

    bank_regs_t bank_d, bank_q;
    logic [NSECT-1:0] set_mask;

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign set_mask[g] = set_fire && (set_sect == SECT_W'(g));
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.lock = bank_q.lock | set_mask;
    end

    assign lock_q   = bank_q.lock;
    assign lock_eff = bank_d.lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl
    import sector_lock_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              req_valid,
    input  logic [SECT_W-1:0] req_sect,
    output logic              req_allow,
    output logic              req_deny,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              id_mode,
    output logic [7:0]        rd_data
);

    localparam int OFS_W  = ADDR_W - SECT_W;
    localparam int NSECT  = 1 << SECT_W;
    localparam int LK_OFS = 2;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
    } top_regs_t;

    top_regs_t top_d, top_q;

    logic              set_fire;
    logic [SECT_W-1:0] set_sect;
    logic [NSECT-1:0]  lock_q;
    logic [NSECT-1:0]  lock_eff;
    logic [SECT_W-1:0] rd_sect;
    logic [OFS_W-1:0]  rd_ofs;

    slc_cmd_seq #(.OFS_W(OFS_W), .SECT_W(SECT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ofs   (wr_addr[OFS_W-1:0]),
        .wr_sect  (wr_addr[ADDR_W-1:OFS_W]),
        .wr_data  (wr_data),
        .set_fire (set_fire),
        .set_sect (set_sect)
    );

    slc_lock_bank #(.SECT_W(SECT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_fire (set_fire),
        .set_sect (set_sect),
        .lock_q   (lock_q),
        .lock_eff (lock_eff)
    );

    assign rd_sect = rd_addr[ADDR_W-1:OFS_W];
    assign rd_ofs  = rd_addr[OFS_W-1:0];

    // requests see a lock that lands in the same cycle
    assign req_deny  = req_valid &&  lock_eff[req_sect];
    assign req_allow = req_valid && !lock_eff[req_sect];

    always_comb begin
        top_d         = top_q;
        top_d.rd_data = '0;
        if (rd_en && id_mode && (rd_ofs == OFS_W'(LK_OFS)))
            top_d.rd_data = {{(DATA_W-1){1'b0}}, lock_eff[rd_sect]};
    end

    assign rd_data = top_q.rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

endmodule

// File: rtl/sector_lock_ctrl_chk.sv
module sector_lock_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int SECT_W = 3,
    localparam int OFS_W = ADDR_W - SECT_W,
    localparam int NSECT = 1 << SECT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SECT_W-1:0] req_sect,
    input logic              req_allow,
    input logic              req_deny,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              id_mode,
    input logic [7:0]        rd_data,
    input logic              set_fire,
    input logic [NSECT-1:0]  lock_q
);

    logic rd_lk;
    assign rd_lk = rd_en && id_mode && (rd_addr[OFS_W-1:0] == OFS_W'(2));

    // R1
    rst_clear_chk: assert property (@(posedge clk) $rose(rst_n) |-> lock_q == '0);

    // R2
    single_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lock_q & ~$past(lock_q)) <= 1);

    // R2
    set_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != $past(lock_q)) |-> $past(set_fire));

    // R3
    locked_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lock_q[req_sect]) |-> (req_deny && !req_allow));

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_allow && !req_deny));

    // R4
    one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_allow != req_deny));

    // R5
    lk_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lk |=> rd_data[7:1] == 7'd0);

    // R6
    other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lk |=> rd_data == 8'd0);

    // R8
    sticky_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & $past(lock_q)) == $past(lock_q));

endmodule

bind sector_lock_ctrl sector_lock_ctrl_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_sect  (req_sect),
    .req_allow (req_allow),
    .req_deny  (req_deny),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .id_mode   (id_mode),
    .rd_data   (rd_data),
    .set_fire  (set_fire),
    .lock_q    (lock_q)
);

// File: tb/sector_lock_ctrl_tb.sv
module sector_lock_ctrl_tb;

    localparam int ADDR_W = 16;
    localparam int SECT_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              req_valid = 1'b0;
    logic [SECT_W-1:0] req_sect = '0;
    logic              req_allow, req_deny;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              id_mode = 1'b0;
    logic [7:0]        rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] mdl_lock = '0;
    int         mdl_st = 0;
    logic [7:0] pend_rd = '0;
    string      pend_tag = "R1";

    sector_lock_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int seq_next(input int st, input logic [15:0] a, input logic [7:0] d,
                                    output bit fire);
        logic [12:0] o;
        o = a[12:0];
        fire = 0;
        case (st)
            0, 3: return (o == 13'h555 && d == 8'hAA) ? st + 1 : 0;
            1, 4: return (o == 13'h2AA && d == 8'h55) ? st + 1 : 0;
            2:    return (o == 13'h555 && d == 8'h80) ? 3 : 0;
            default: begin fire = (d == 8'h60); return 0; end
        endcase
    endfunction

    function automatic void good_step(input int st, input logic [2:0] s,
                                      output logic [15:0] a, output logic [7:0] d);
        case (st)
            0, 3:    begin a = {s, 13'h555}; d = 8'hAA; end
            1, 4:    begin a = {s, 13'h2AA}; d = 8'h55; end
            2:       begin a = {s, 13'h555}; d = 8'h80; end
            default: begin a = {s, 13'($urandom)}; d = 8'h60; end
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; req_valid = 0; rd_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl_lock = '0; mdl_st = 0; pend_rd = '0; pend_tag = "R1";
    endtask

    // one bus cycle: drive at negedge, judge outputs, advance model
    task automatic cyc(input bit w, input logic [15:0] wa, input logic [7:0] wd,
                       input bit rq, input logic [2:0] rs,
                       input bit r, input logic [15:0] ra, input bit idm, input string tag);
        bit fire;
        int nst;
        logic [7:0] eff;
        @(negedge clk);
        chk(pend_tag, rd_data, pend_rd);
        wr_en = w; wr_addr = wa; wr_data = wd;
        req_valid = rq; req_sect = rs;
        rd_en = r; rd_addr = ra; id_mode = idm;
        fire = 0;
        nst = mdl_st;
        if (w) nst = seq_next(mdl_st, wa, wd, fire);
        eff = mdl_lock | (fire ? (8'd1 << wa[15:13]) : 8'd0);
        #1;
        chk({tag, (eff[rs] ? " R3" : " R4")}, {6'd0, req_allow, req_deny},
            {6'd0, rq && !eff[rs], rq && eff[rs]});
        if (r && idm && ra[12:0] == 13'd2) begin
            pend_rd = {7'd0, eff[ra[15:13]]}; pend_tag = {tag, " R5"};
        end else begin
            pend_rd = '0; pend_tag = {tag, " R6"};
        end
        mdl_lock = eff;
        mdl_st = nst;
    endtask

    task automatic idle(input string tag);
        cyc(0, '0, '0, 0, '0, 0, '0, 0, tag);
    endtask

    task automatic full_lock(input logic [2:0] s, input string tag);
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a; logic [7:0] d;
            good_step(k, 3'($urandom), a, d);
            if (k == 5) a[15:13] = s;
            cyc(1, a, d, 0, '0, 0, '0, 0, tag);
        end
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < 8; s++)
            cyc(0, '0, '0, 1, 3'(s), 1, {3'(s), 13'd2}, 1, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC7_0A11));
        do_reset();
        read_all("R1");

        // R2, R10: lock sector 5 with reads and requests interleaved
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a; logic [7:0] d;
            good_step(k, 3'(k), a, d);
            if (k == 5) a[15:13] = 3'd5;
            cyc(1, a, d, 0, '0, 0, '0, 0, "R2");
            cyc(0, '0, '0, 1, 3'd5, 1, {3'd5, 13'd2}, 1, "R10");
        end
        read_all("R2");

        // R6: non-id read and wrong offset read of a locked sector
        cyc(0, '0, '0, 0, '0, 1, {3'd5, 13'd2}, 0, "R6");
        cyc(0, '0, '0, 0, '0, 1, {3'd5, 13'd3}, 1, "R6");
        idle("R6");

        // R7: abort after third step, then the tail alone must not lock
        cyc(1, 16'h0555, 8'hAA, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h02AA, 8'h55, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h0555, 8'h80, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h0555, 8'h81, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h02AA, 8'h55, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h4000, 8'h60, 0, '0, 0, '0, 0, "R7");
        // a mismatch carrying AA@555 is not itself a first step
        cyc(1, 16'h0555, 8'hAA, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h0555, 8'hAA, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h02AA, 8'h55, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h0555, 8'h80, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h0555, 8'hAA, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h02AA, 8'h55, 0, '0, 0, '0, 0, "R7");
        cyc(1, 16'h4000, 8'h60, 0, '0, 0, '0, 0, "R7");
        read_all("R7");

        // R9: completing write, request and read on sector 2 together
        for (int k = 0; k < 5; k++) begin
            logic [15:0] a; logic [7:0] d;
            good_step(k, 3'd0, a, d);
            cyc(1, a, d, 0, '0, 0, '0, 0, "R9");
        end
        cyc(1, {3'd2, 13'h0100}, 8'h60, 1, 3'd2, 1, {3'd2, 13'd2}, 1, "R9");
        cyc(0, '0, '0, 1, 3'd3, 0, '0, 0, "R9");

        // R8: second lock of same sector and noise keep flags
        full_lock(3'd5, "R8");
        for (int i = 0; i < 40; i++)
            cyc(1, 16'($urandom), 8'($urandom), 1, 3'($urandom), 0, '0, 0, "R8");
        read_all("R8");

        // R1: reset clears flags
        do_reset();
        read_all("R1");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a; logic [7:0] d;
            bit w;
            if (i % 600 == 599) do_reset();
            w = ($urandom % 2) == 0;
            if (($urandom % 10) < 8) good_step(mdl_st, 3'($urandom), a, d);
            else begin
                a = 16'($urandom);
                case ($urandom % 5)
                    0: d = 8'hAA; 1: d = 8'h55; 2: d = 8'h80; 3: d = 8'h60;
                    default: d = 8'($urandom);
                endcase
            end
            cyc(w, a, d, ($urandom % 2) == 0, 3'($urandom),
                ($urandom % 2) == 0, {3'($urandom), (($urandom % 3) != 0) ? 13'd2 : 13'($urandom)},
                ($urandom % 4) != 0, "RND R8");
        end
        idle("END");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule